// File: doc/BRIEF.md
# Serial DAC Register Interface

This block is the command front end of a 16-bit voltage-output DAC. A host drives an active-low frame select, a serial clock and a data line. Each frame of 24 bits is sampled into the block and decoded into a register write or a read request. The block holds the DAC code, a control word, a clear code and a write-only software strobe register. It also drives a serial data-out line that returns a requested register during the frame that follows the request.

All three serial pins are taken through synchronisers into the system clock domain. Data is sampled on the rising serial clock edge, and data-out advances on the falling edge. A frame takes effect only when the select is released after exactly 24 serial clocks. Writing the strobe register raises one-cycle load and clear pulses, and the clear pulse also copies the clear code into the DAC code.

Top module: `sdac_serial_if`

## Requirements
- R1: After reset, `dacCode` is 16'h8000 (the zero-volt code), `ctrlWord` is 20'h00002, `clampEn` is 1 (it follows control bit 1), `sdo` is 0, and both pulse outputs are 0.
- R2: A frame is sampled on rising `sclk` edges while `frameSel_n` is low, MSB first. Bit 23 is the direction (0 write, 1 read), bits 22:20 are the address and bits 19:0 are the payload. A write to address 001 loads payload bits 19:4 into `dacCode`, and payload bits 3:0 are ignored.
- R3: A write to address 010 stores all 20 payload bits in `ctrlWord`, and `clampEn` equals the new bit 1.
- R4: A frame that ends after fewer or more than 24 rising `sclk` edges changes no register and arms no response.
- R5: Address 000 with either direction, addresses 101 to 111 with either direction, and reads of address 100 change no register and arm no response.
- R6: A write to address 011 stores payload bits 19:4 as the clear code. A write to address 100 with payload bit 0 set gives exactly one cycle of `loadPulse`. The same write with payload bit 1 set gives exactly one cycle of `clearPulse` and sets `dacCode` to the clear code.
- R7: After a valid read of address 001, 010 or 011, the next frame shifts out 24 bits on `sdo`, MSB first. The first bit is valid from the start of the frame and each further bit follows a falling `sclk` edge. The value is {1, address, contents}, where the DAC and clear codes appear in bits 19:4 with bits 3:0 at zero.
- R8: The response holds the register value at the end of the read frame. A write carried by the response frame itself takes effect only after that frame, and a frame with no armed response shifts out zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Active-low asynchronous reset |
| frameSel_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| dacCode | output | 16 | Current DAC code |
| ctrlWord | output | 20 | Control register contents |
| clampEn | output | 1 | Output clamp enable (control bit 1) |
| loadPulse | output | 1 | One-cycle load strobe |
| clearPulse | output | 1 | One-cycle clear strobe |

## Verification
Two things can happen during the same frame: returning a captured response and decoding a new command. They meet when a read of the DAC code is followed directly by a frame that writes the DAC code, and when a read is followed by another read. The bench judges the first case in two ways. The bits shifted out must carry the value from before the write, and `dacCode` must take the new code only after select is released. In the second case, the second frame must return the first register, and the NOP frame after it must return the second register.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int FRAME_W  = 24;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 20;
  localparam int CODE_W   = 16;
  localparam int CODE_LSB = DATA_W - CODE_W;
  localparam int HDR_W    = ADDR_W + 1;

  localparam logic [ADDR_W-1:0] ADR_DAC  = 3'b001;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'b010;
  localparam logic [ADDR_W-1:0] ADR_CLR  = 3'b011;
  localparam logic [ADDR_W-1:0] ADR_SOFT = 3'b100;

  typedef struct packed {
    logic sampleBit;
    logic advanceOut;
    logic frameStart;
    logic wrDac;
    logic wrCtrl;
    logic wrClr;
    logic wrSoft;
    logic rdCapture;
  } strobe_t;
endpackage

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
  import sdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frameSel_n,
  input  logic             sclk,
  input  logic             sdi,
  input  logic [HDR_W-1:0] header,
  output strobe_t          stb,
  output logic             sdiSync
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic [SYNC_STAGES-1:0] selPipe, sclkPipe, sdiPipe;
  logic selPrev, sclkPrev;
  logic [CNT_W-1:0] bitCount;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selPipe  <= '1;
      sclkPipe <= '0;
      sdiPipe  <= '0;
      selPrev  <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      selPipe  <= {selPipe[SYNC_STAGES-2:0], frameSel_n};
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclk};
      sdiPipe  <= {sdiPipe[SYNC_STAGES-2:0], sdi};
      selPrev  <= selPipe[SYNC_STAGES-1];
      sclkPrev <= sclkPipe[SYNC_STAGES-1];
    end
  end

  logic selNow, sclkNow, frameActive, sclkRise, sclkFall;
  logic frameStart, frameEnd, commit, rw;
  logic [ADDR_W-1:0] addr;

  assign selNow      = selPipe[SYNC_STAGES-1];
  assign sclkNow     = sclkPipe[SYNC_STAGES-1];
  assign sdiSync     = sdiPipe[SYNC_STAGES-1];
  assign frameActive = !selNow;
  assign sclkRise    = sclkNow && !sclkPrev;
  assign sclkFall    = !sclkNow && sclkPrev;
  assign frameStart  = selPrev && !selNow;
  assign frameEnd    = !selPrev && selNow;
  assign commit      = frameEnd && (bitCount == CNT_FULL);
  assign rw          = header[HDR_W-1];
  assign addr        = header[ADDR_W-1:0];

  // Bit counter saturates one past a full frame so over-long frames are rejected.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bitCount <= '0;
    else if (frameStart) bitCount <= '0;
    else if (frameActive && sclkRise && bitCount != CNT_OVER) bitCount <= bitCount + 1'b1;
  end

  always_comb begin
    stb            = '0;
    stb.sampleBit  = frameActive && sclkRise && !frameStart;
    stb.advanceOut = frameActive && sclkFall && !frameStart;
    stb.frameStart = frameStart;
    stb.wrDac      = commit && !rw && (addr == ADR_DAC);
    stb.wrCtrl     = commit && !rw && (addr == ADR_CTRL);
    stb.wrClr      = commit && !rw && (addr == ADR_CLR);
    stb.wrSoft     = commit && !rw && (addr == ADR_SOFT);
    stb.rdCapture  = commit && rw &&
                     (addr == ADR_DAC || addr == ADR_CTRL || addr == ADR_CLR);
  end

  AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.wrDac, stb.wrCtrl, stb.wrClr, stb.wrSoft, stb.rdCapture})); // R5
  AST_COMMIT_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wrDac || stb.wrCtrl || stb.wrClr || stb.wrSoft || stb.rdCapture) |-> $past(frameActive)); // R4
endmodule

// File: rtl/sdac_datapath.sv
module sdac_datapath
  import sdac_pkg::*;
#(
  parameter logic [CODE_W-1:0] ZERO_CODE  = 16'h8000,
  parameter logic [DATA_W-1:0] CTRL_RESET = 20'h00002,
  parameter int                CLAMP_BIT  = 1,
  parameter int                LOAD_BIT   = 0,
  parameter int                CLEAR_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic              sdiSync,
  output logic [HDR_W-1:0]  header,
  output logic [CODE_W-1:0] dacCode,
  output logic [DATA_W-1:0] ctrlWord,
  output logic              clampEn,
  output logic              loadPulse,
  output logic              clearPulse,
  output logic              sdo
);
  logic [FRAME_W-1:0] inShift, outShift, respReg;
  logic               respPending;
  logic [CODE_W-1:0]  dacReg, clrReg;
  logic [DATA_W-1:0]  ctrlReg, payload, readSel;
  logic [CODE_W-1:0]  codeField;
  logic               clearReq;

  assign header    = inShift[FRAME_W-1 -: HDR_W];
  assign payload   = inShift[DATA_W-1:0];
  assign codeField = payload[DATA_W-1:CODE_LSB];
  assign clearReq  = stb.wrSoft && payload[CLEAR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inShift <= '0;
    else if (stb.sampleBit) inShift <= {inShift[FRAME_W-2:0], sdiSync};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dacReg     <= ZERO_CODE;
      ctrlReg    <= CTRL_RESET;
      clrReg     <= '0;
      loadPulse  <= 1'b0;
      clearPulse <= 1'b0;
    end else begin
      loadPulse  <= stb.wrSoft && payload[LOAD_BIT];
      clearPulse <= clearReq;
      if (stb.wrDac) dacReg <= codeField;
      else if (clearReq) dacReg <= clrReg;
      if (stb.wrCtrl) ctrlReg <= payload;
      if (stb.wrClr) clrReg <= codeField;
    end
  end

  always_comb begin
    case (header[ADDR_W-1:0])
      ADR_DAC:  readSel = {dacReg, {CODE_LSB{1'b0}}};
      ADR_CTRL: readSel = ctrlReg;
      ADR_CLR:  readSel = {clrReg, {CODE_LSB{1'b0}}};
      default:  readSel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respReg     <= '0;
      respPending <= 1'b0;
      outShift    <= '0;
    end else begin
      if (stb.rdCapture) begin
        respReg     <= {header, readSel};
        respPending <= 1'b1;
      end else if (stb.frameStart) begin
        respPending <= 1'b0;
      end
      if (stb.frameStart) outShift <= respPending ? respReg : '0;
      else if (stb.advanceOut) outShift <= {outShift[FRAME_W-2:0], 1'b0};
    end
  end

  assign sdo      = outShift[FRAME_W-1];
  assign dacCode  = dacReg;
  assign ctrlWord = ctrlReg;
  assign clampEn  = ctrlReg[CLAMP_BIT];

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    loadPulse |=> !loadPulse); // R6
  AST_CLEAR_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    clearPulse |-> dacReg == clrReg); // R6
  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.wrDac && !clearReq) |=> $stable(dacReg)); // R4
  AST_RESP_CODE_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (respPending && respReg[DATA_W +: ADDR_W] != ADR_CTRL) |-> respReg[CODE_LSB-1:0] == '0); // R7
endmodule

// File: rtl/sdac_serial_if.sv
module sdac_serial_if
  import sdac_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [CODE_W-1:0] ZERO_CODE   = 16'h8000,
  parameter logic [DATA_W-1:0] CTRL_RESET  = 20'h00002,
  parameter int                CLAMP_BIT   = 1,
  parameter int                LOAD_BIT    = 0,
  parameter int                CLEAR_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frameSel_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic [CODE_W-1:0] dacCode,
  output logic [DATA_W-1:0] ctrlWord,
  output logic              clampEn,
  output logic              loadPulse,
  output logic              clearPulse
);
  strobe_t          stb;
  logic             sdiSync;
  logic [HDR_W-1:0] header;

  sdac_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frameSel_n(frameSel_n), .sclk(sclk), .sdi(sdi),
    .header(header), .stb(stb), .sdiSync(sdiSync)
  );

  sdac_datapath #(
    .ZERO_CODE(ZERO_CODE), .CTRL_RESET(CTRL_RESET), .CLAMP_BIT(CLAMP_BIT),
    .LOAD_BIT(LOAD_BIT), .CLEAR_BIT(CLEAR_BIT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .sdiSync(sdiSync), .header(header),
    .dacCode(dacCode), .ctrlWord(ctrlWord), .clampEn(clampEn),
    .loadPulse(loadPulse), .clearPulse(clearPulse), .sdo(sdo)
  );
endmodule

// File: tb/sdac_serial_if_bench.sv
module sdac_serial_if_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SCLK_HALF  = 50;

  logic clk = 1'b0, rst_n = 1'b0, frameSel_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, clampEn, loadPulse, clearPulse;
  logic [15:0] dacCode;
  logic [19:0] ctrlWord;
  int checks = 0, failures = 0, loadCnt = 0, clearCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdac_serial_if u_sdac_serial_if (
    .clk(clk), .rst_n(rst_n), .frameSel_n(frameSel_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .dacCode(dacCode), .ctrlWord(ctrlWord), .clampEn(clampEn),
    .loadPulse(loadPulse), .clearPulse(clearPulse)
  );

  always @(negedge clk) begin
    if (rst_n && loadPulse) loadCnt++;
    if (rst_n && clearPulse) clearCnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [23:0] word, input int nClk, output logic [23:0] got);
    got = '0;
    @(negedge clk);
    frameSel_n = 1'b0;
    for (int i = 0; i < nClk; i++) begin
      sdi = (i < 24) ? word[23-i] : 1'b0;
      #(SCLK_HALF);
      if (i < 24) got[23-i] = sdo;
      sclk = 1'b1;
      #(SCLK_HALF);
      sclk = 1'b0;
    end
    #(SCLK_HALF);
    frameSel_n = 1'b1;
    #(10*CLK_PERIOD);
  endtask

  task automatic testReset();
    check("R1 dacCode", dacCode, 32'h8000);
    check("R1 ctrlWord", ctrlWord, 32'h00002);
    check("R1 clampEn", clampEn, 1);
    check("R1 sdo", sdo, 0);
    check("R1 pulses", {loadPulse, clearPulse}, 0);
  endtask

  task automatic testDacWrite();
    logic [23:0] got;
    sendFrame({1'b0, 3'b001, 16'hABCD, 4'hF}, 24, got);
    check("R2 dac write", dacCode, 32'hABCD);
    sendFrame({1'b1, 3'b001, 20'h0}, 24, got);
    sendFrame(24'h0, 24, got);
    check("R7 dac readback", got, 32'h9ABCD0);
  endtask

  task automatic testCtrl();
    logic [23:0] got;
    sendFrame({1'b0, 3'b010, 20'h12345}, 24, got);
    check("R3 ctrlWord", ctrlWord, 32'h12345);
    check("R3 clampEn low", clampEn, 0);
    sendFrame({1'b1, 3'b010, 20'h0}, 24, got);
    sendFrame(24'h0, 24, got);
    check("R7 ctrl readback", got, 32'hA12345);
    sendFrame({1'b0, 3'b010, 20'h00002}, 24, got);
    check("R3 clampEn high", clampEn, 1);
  endtask

  task automatic testLength();
    logic [23:0] got;
    sendFrame({1'b0, 3'b001, 16'h1111, 4'h0}, 23, got);
    check("R4 short frame", dacCode, 32'hABCD);
    sendFrame({1'b0, 3'b001, 16'h2222, 4'h0}, 25, got);
    check("R4 long frame", dacCode, 32'hABCD);
    sendFrame({1'b1, 3'b010, 20'h0}, 23, got);
    sendFrame(24'h0, 24, got);
    check("R4 short read arms nothing", got, 0);
  endtask

  task automatic testNop();
    logic [23:0] got;
    sendFrame({1'b0, 3'b000, 20'hFFFFF}, 24, got);
    sendFrame({1'b1, 3'b000, 20'hFFFFF}, 24, got);
    for (int a = 5; a < 8; a++) sendFrame({1'b0, 3'(a), 20'h33330}, 24, got);
    check("R5 nop dac", dacCode, 32'hABCD);
    check("R5 nop ctrl", ctrlWord, 32'h00002);
    check("R5 nop pulses", loadCnt + clearCnt, 0);
    sendFrame({1'b1, 3'b100, 20'h0}, 24, got);
    sendFrame(24'h0, 24, got);
    check("R5 read soft no response", got, 0);
    sendFrame({1'b1, 3'b110, 20'h0}, 24, got);
    sendFrame(24'h0, 24, got);
    check("R5 read unused no response", got, 0);
  endtask

  task automatic testSoft();
    logic [23:0] got;
    sendFrame({1'b0, 3'b011, 16'h5555, 4'h7}, 24, got);
    check("R6 clear code no dac change", dacCode, 32'hABCD);
    sendFrame({1'b0, 3'b100, 20'h00001}, 24, got);
    check("R6 load pulse count", loadCnt, 1);
    check("R6 load keeps dac", dacCode, 32'hABCD);
    sendFrame({1'b0, 3'b100, 20'h00002}, 24, got);
    check("R6 clear pulse count", clearCnt, 1);
    check("R6 clear copies code", dacCode, 32'h5555);
    check("R6 no extra load", loadCnt, 1);
    sendFrame({1'b1, 3'b011, 20'h0}, 24, got);
    sendFrame(24'h0, 24, got);
    check("R7 clear readback", got, 32'hB55550);
  endtask

  task automatic testOverlap();
    logic [23:0] got;
    sendFrame({1'b1, 3'b001, 20'h0}, 24, got);
    sendFrame({1'b0, 3'b001, 16'h7777, 4'h0}, 24, got);
    check("R8 response holds old code", got, 32'h955550);
    check("R8 write after response frame", dacCode, 32'h7777);
    sendFrame(24'h0, 24, got);
    check("R8 no armed response", got, 0);
    sendFrame({1'b1, 3'b010, 20'h0}, 24, got);
    sendFrame({1'b1, 3'b011, 20'h0}, 24, got);
    check("R8 read then read first", got, 32'hA00002);
    sendFrame(24'h0, 24, got);
    check("R8 read then read second", got, 32'hB55550);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*4);
    @(negedge clk);
    rst_n = 1'b1;
    #(CLK_PERIOD*4);
    testReset();
    testDacWrite();
    testCtrl();
    testLength();
    testNop();
    testSoft();
    testOverlap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule